// File: doc/BRIEF.md
# Loop Reprogramming Command Sequencer

This block runs on the host side of a clock synthesizer and steps a register-write bus through the sequence that keeps the synthesizer's loop from losing lock while it is reprogrammed. The sequence is needed whenever a change would move the loop oscillator by more than 250 ppm, or when the input prescaler or the feedback divider's numerator or denominator is rewritten.

A start pulse launches the sequence. The block first writes two unlock bytes. It then waits a settle time, and the length of that wait depends on the device grade. After the wait, the bus belongs to an external client. The client asks for the bus, receives a grant, makes its own register changes, and signals when it has finished. The sequencer then sets the soft-reset bit with a read-modify-write and ends with two closing writes. Busy and done outputs let a controller know when the synthesizer is safe to touch again.

Wait lengths are counted in clock cycles from a cycles-per-millisecond parameter. Every bus access holds its address, data and strobe until the bus returns ready.

Top module: `pll_reinit_seq`

## Requirements
- R1: After reset, busy, done, grant, write strobe and read strobe are all low.
- R2: An accepted start first writes 0xC0 to address 0x0B24 and then writes 0x00 to address 0x0B25, in that order.
- R3: A bus access (write strobe or read strobe high) keeps its address, write data and strobe unchanged until the cycle in which ready is high. The next access starts only after that cycle.
- R4: After the second unlock write completes, the block waits 300*CYC_PER_MS cycles when the grade input was 0 and 625*CYC_PER_MS cycles when it was 1. Both strobes stay low during the wait.
- R5: The grant rises only after the wait and only while the client request is high. It stays high until the client's done input is seen. Both strobes stay low while the grant is high.
- R6: After the client finishes, the block reads address 0x001C. It then writes to 0x001C the read data with bit 0 set and all other bits unchanged.
- R7: After the soft-reset write, the block writes 0xC3 to 0x0B24 and then 0x02 to 0x0B25.
- R8: Busy is high from the cycle after an accepted start until the last closing write is accepted. Done is a single-cycle pulse in the cycle after that, with busy low.
- R9: A start pulse while busy is high is ignored: no second sequence follows.
- R10: The grade is sampled when start is accepted. Changing the grade input later does not change the current wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| precision_i | input | 1 | Grade select: 1 selects the long wait |
| cli_req_i | input | 1 | Client asks for the bus |
| cli_grant_o | output | 1 | Bus handed to the client |
| cli_done_i | input | 1 | Client has finished its changes |
| bus_addr_o | output | 16 | Access address |
| bus_wdata_o | output | 8 | Write data |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_rdata_i | input | 8 | Read data, valid with ready |
| bus_rdy_i | input | 1 | Access completes in this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CYC_PER_MS = 4. This brings the standard wait to 1200 cycles and the precision wait to 2500 cycles, so both grades can be measured to the exact cycle in a short run. The other parameters keep their defaults, so the 300 and 625 ms ratios are the real ones. The bench varies the bus ready latency from zero to two cycles and uses read values with bit 0 clear and with bit 0 set. This covers the stable-hold rule and both outcomes of the read-modify-write.

// File: rtl/pll_reinit_pkg.sv
// Shared constants and state type for the loop reprogramming sequencer.
// Assumes a 16-bit register address space and 8-bit register data.
package pll_reinit_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 16'h0B24;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 16'h0B25;
    localparam logic [ADDR_W-1:0] SRST_ADDR  = 16'h001C;

    localparam logic [DATA_W-1:0] UNLOCK_A = 8'hC0;
    localparam logic [DATA_W-1:0] UNLOCK_B = 8'h00;
    localparam logic [DATA_W-1:0] RELOCK_A = 8'hC3;
    localparam logic [DATA_W-1:0] RELOCK_B = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_A,
        ST_PRE_B,
        ST_SETTLE,
        ST_WAIT_REQ,
        ST_WINDOW,
        ST_SRST_RD,
        ST_SRST_WR,
        ST_POST_A,
        ST_POST_B
    } seq_state_e;
endpackage

// File: rtl/settle_timer.sv
// Down-counter for the settle wait. A load pulse sets the count to the
// chosen wait minus one. While run_i is high the count drops by one per cycle
// down to zero, and expired_o flags zero.
// Assumes that CYC_PER_MS is at least 1.
module settle_timer #(
    parameter int CYC_PER_MS = 100000,
    parameter int STD_MS     = 300,
    parameter int PREC_MS    = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic prec_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int STD_CYC  = STD_MS * CYC_PER_MS;
    localparam int PREC_CYC = PREC_MS * CYC_PER_MS;
    localparam int MAX_CYC  = (PREC_CYC > STD_CYC) ? PREC_CYC : STD_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load the grade-dependent count, or count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= prec_i ? CNT_W'(PREC_CYC - 1) : CNT_W'(STD_CYC - 1);
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/seq_cmd_decode.sv
// Maps the sequencer state to the bus access it presents: strobes,
// address and write data. The soft-reset write data comes in from the
// captured read-modify-write value.
// Assumes that states without an access drive both strobes low.
module seq_cmd_decode
    import pll_reinit_pkg::*;
(
    input  seq_state_e        state_i,
    input  logic [DATA_W-1:0] rmw_i,
    output logic              wr_o,
    output logic              rd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    // Choose the access for the current step.
    always_comb begin
        wr_o    = 1'b0;
        rd_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        unique case (state_i)
            ST_PRE_A:   begin wr_o = 1'b1; addr_o = KEY_ADDR_A; wdata_o = UNLOCK_A; end
            ST_PRE_B:   begin wr_o = 1'b1; addr_o = KEY_ADDR_B; wdata_o = UNLOCK_B; end
            ST_SRST_RD: begin rd_o = 1'b1; addr_o = SRST_ADDR; end
            ST_SRST_WR: begin wr_o = 1'b1; addr_o = SRST_ADDR;  wdata_o = rmw_i; end
            ST_POST_A:  begin wr_o = 1'b1; addr_o = KEY_ADDR_A; wdata_o = RELOCK_A; end
            ST_POST_B:  begin wr_o = 1'b1; addr_o = KEY_ADDR_B; wdata_o = RELOCK_B; end
            default:    ;
        endcase
    end
endmodule

// File: rtl/pll_reinit_seq.sv
// Top of the loop reprogramming sequencer. The steps are: unlock writes,
// a timed settle, the client window, a soft-reset read-modify-write and
// the relock writes. Assumes that an external mux gives the client the
// register bus while cli_grant_o is high. Each access of this block
// completes in the cycle in which bus_rdy_i is high.
module pll_reinit_seq
    import pll_reinit_pkg::*;
#(
    parameter int CYC_PER_MS = 100000,
    parameter int STD_MS     = 300,
    parameter int PREC_MS    = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              precision_i,
    input  logic              cli_req_i,
    output logic              cli_grant_o,
    input  logic              cli_done_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_wr_o,
    output logic              bus_rd_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_rdy_i,
    output logic              busy_o,
    output logic              done_o
);
    seq_state_e        state_q;
    logic              prec_q;
    logic [DATA_W-1:0] rmw_q;
    logic              done_q;
    logic              expired;
    logic              timer_load;

    assign timer_load = (state_q == ST_PRE_B) && bus_rdy_i;

    settle_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .STD_MS     (STD_MS),
        .PREC_MS    (PREC_MS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (timer_load),
        .prec_i    (prec_q),
        .run_i     (state_q == ST_SETTLE),
        .expired_o (expired)
    );

    seq_cmd_decode u_decode (
        .state_i (state_q),
        .rmw_i   (rmw_q),
        .wr_o    (bus_wr_o),
        .rd_o    (bus_rd_o),
        .addr_o  (bus_addr_o),
        .wdata_o (bus_wdata_o)
    );

    // Advance through the steps; latch the grade and the read-modify-write value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prec_q  <= 1'b0;
            rmw_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_PRE_A;
                    prec_q  <= precision_i;
                end
                ST_PRE_A:    if (bus_rdy_i) state_q <= ST_PRE_B;
                ST_PRE_B:    if (bus_rdy_i) state_q <= ST_SETTLE;
                ST_SETTLE:   if (expired)   state_q <= ST_WAIT_REQ;
                ST_WAIT_REQ: if (cli_req_i) state_q <= ST_WINDOW;
                ST_WINDOW:   if (cli_done_i) state_q <= ST_SRST_RD;
                ST_SRST_RD: if (bus_rdy_i) begin
                    rmw_q   <= bus_rdata_i | DATA_W'(1);
                    state_q <= ST_SRST_WR;
                end
                ST_SRST_WR:  if (bus_rdy_i) state_q <= ST_POST_A;
                ST_POST_A:   if (bus_rdy_i) state_q <= ST_POST_B;
                ST_POST_B: if (bus_rdy_i) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign cli_grant_o = (state_q == ST_WINDOW);
endmodule

// File: rtl/pll_reinit_seq_chk.sv
// Checker for the sequencer's port-level rules, bound to the top module.
// Assumes that the reset is synchronous and active low.
module pll_reinit_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        cli_req_i,
    input logic        cli_grant_o,
    input logic [15:0] bus_addr_o,
    input logic [7:0]  bus_wdata_o,
    input logic        bus_wr_o,
    input logic        bus_rd_o,
    input logic        bus_rdy_i,
    input logic        busy_o,
    input logic        done_o
);
    a_r3_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_o && !bus_rdy_i) |=> (bus_wr_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));

    a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o && !bus_rdy_i) |=> (bus_rd_o && $stable(bus_addr_o)));

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_o && bus_rd_o));

    a_r5_grant_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cli_grant_o |-> (!bus_wr_o && !bus_rd_o && busy_o));

    a_r5_grant_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cli_grant_o) |-> $past(cli_req_i));

    a_r6_srst_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_o && bus_addr_o == 16'h001C) |-> bus_wdata_o[0]);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

bind pll_reinit_seq pll_reinit_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cli_req_i   (cli_req_i),
    .cli_grant_o (cli_grant_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_wr_o    (bus_wr_o),
    .bus_rd_o    (bus_rd_o),
    .bus_rdy_i   (bus_rdy_i),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/pll_reinit_seq_tb.sv
`timescale 1ns/1ps
module pll_reinit_seq_tb;
    localparam int CPM      = 4;
    localparam int STD_WAIT = 300 * CPM;
    localparam int PRE_WAIT = 625 * CPM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, prec = 1'b0, cli_req = 1'b0, cli_done = 1'b0;
    logic grant, wr, rd, rdy = 1'b0, busy, done;
    logic [15:0] addr;
    logic [7:0]  wdata, rdata = 8'h00;
    int n_cmp = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    pll_reinit_seq #(.CYC_PER_MS(CPM)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .precision_i(prec),
        .cli_req_i(cli_req), .cli_grant_o(grant), .cli_done_i(cli_done),
        .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_wr_o(wr), .bus_rd_o(rd),
        .bus_rdata_i(rdata), .bus_rdy_i(rdy), .busy_o(busy), .done_o(done)
    );

    // Expected accesses: {read, address, data}. The data of the soft-reset write is computed.
    localparam logic [24:0] EXP_TX [6] = '{
        {1'b0, 16'h0B24, 8'hC0}, {1'b0, 16'h0B25, 8'h00},
        {1'b1, 16'h001C, 8'h00}, {1'b0, 16'h001C, 8'h00},
        {1'b0, 16'h0B24, 8'hC3}, {1'b0, 16'h0B25, 8'h02}
    };

    function automatic string tag_of(input int i);
        if (i < 2) return "R2";
        if (i < 4) return "R6";
        return "R7";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: wait for a strobe, check it, hold for lat cycles, then answer ready.
    task automatic serve(input int i, input int lat, input logic [7:0] rv);
        logic [24:0] e;
        int guard;
        e = EXP_TX[i];
        if (i == 3) e[7:0] = rv | 8'h01;
        guard = 0;
        while (!(wr || rd) && guard < 100) begin @(negedge clk); guard++; end
        chk({tag_of(i), " access"}, {7'd0, rd, addr, wdata}, {7'd0, e});
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk("R3 hold", {7'd0, rd, addr, wdata}, {7'd0, e});
            chk("R3 strobe held", {31'd0, wr | rd}, 32'd1);
        end
        rdata = rv;
        rdy = 1'b1;
        @(negedge clk);
        rdy = 1'b0;
    endtask

    // Full sequence; wait_exp is the expected settle length.
    task automatic run_seq(input logic grade, input logic grade_late, input int wait_exp,
                           input logic [7:0] rv, input logic poke_start);
        int cnt;
        prec = grade;
        cli_req = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        prec = grade_late;
        chk("R8 busy after start", {31'd0, busy}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            if (i == 2) begin
                cnt = 0;
                while (!grant && cnt < 4000) begin
                    if (wr || rd) chk("R4 bus idle in wait", {30'd0, wr, rd}, 32'd0);
                    if (poke_start && cnt == 10) start = 1'b1;
                    if (poke_start && cnt == 11) start = 1'b0;
                    @(negedge clk);
                    cnt++;
                end
                chk("R4/R10 wait length", cnt, wait_exp + 1);
                for (int k = 0; k < 3; k++) begin
                    chk("R5 grant held, bus idle", {29'd0, grant, wr, rd}, 32'h4);
                    @(negedge clk);
                end
                cli_done = 1'b1;
                @(negedge clk);
                cli_done = 1'b0;
                cli_req = 1'b0;
                chk("R5 grant released", {31'd0, grant}, 32'd0);
            end
            serve(i, i % 3, rv);
            if (i < 5) chk("R8 busy mid", {31'd0, busy}, 32'd1);
        end
        chk("R8 done pulse, not busy", {30'd0, done, busy}, 32'h2);
        @(negedge clk);
        chk("R8 done single", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk("R1 reset outputs", {27'd0, busy, done, grant, wr, rd}, 32'd0);
        // R2 R4 R6 R7: standard grade, bit 0 clear in the read value
        run_seq(1'b0, 1'b0, STD_WAIT, 8'hA4, 1'b0);
        // R4 R9: precision grade, start poked during the wait
        run_seq(1'b1, 1'b1, PRE_WAIT, 8'h3B, 1'b1);
        repeat (6) begin
            @(negedge clk);
            chk("R9 no restart", {29'd0, busy, wr, rd}, 32'd0);
        end
        // R10: grade changed right after start does not change the wait
        run_seq(1'b0, 1'b1, STD_WAIT, 8'h00, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule